// File: doc/BRIEF.md
# Symmetrical Offset Segmented Decoder

The block turns a 16-bit two's-complement audio sample into the switch controls of a segmented current-steering converter. There are two sections. The coarse section is a bank of 32 equal sources, driven as a thermometer code together with the 5-bit coarse value it encodes. The fine section is an 11-bit binary word for a divider that splits the current of one calibrated source. The analog weighting lies outside this block.

The sample is first turned into offset binary by flipping its sign bit. Half of one fine segment (1024) is then added, and the result saturates at full scale. Bipolar zero therefore falls in the middle of a fine segment and not on a coarse boundary. A step across zero in either direction changes only fine bits, and the coarse thermometer stays where it is.

Samples arrive on a valid/ready stream and go into a one-entry holding register. A separate load strobe copies the holding register into the output registers. Coarse value, thermometer and fine word all change together on that edge.

Back-pressure rules: `in_ready` falls once a sample is held and has not yet been loaded. It is high again in any cycle where `load` is asserted, so a new sample can be accepted on the same edge that loads the previous one. A sample offered while `in_ready` is low is not taken, and the producer must hold it.

Top module: `sosd_decoder`

## Requirements
- R1: After reset the outputs show the decode of sample 0x0000: coarse 16, fine 1024, thermometer 0x0000FFFF. `in_ready` is high.
- R2: A sample is accepted when `in_valid` and `in_ready` are both high. `in_ready` equals "no pending sample OR `load`". An accepted sample stays pending until a load.
- R3: Outputs change only on the edge following a cycle in which `load` is high. Otherwise they hold their value, whatever happens on the stream input.
- R4: A load copies the sample that was held before that edge. A sample accepted on the same edge becomes pending and is not shown. A load with nothing pending shows the held sample again.
- R5: Let level = (sample XOR 0x8000) + 1024, saturated at 65535. The coarse output is level[15:11] and the fine output is level[10:0].
- R6: Thermometer bit k is 1 exactly when k is less than the coarse value. Its population count equals the coarse value, and its set bits are contiguous from bit 0.
- R7: Going from 0xFFFF to 0x0000, coarse and thermometer stay the same (coarse 16). The fine word goes from 1023 to 1024.
- R8: Samples from 0x7BFF to 0x7FFF all give coarse 31 and fine 2047 (saturation at the top).
- R9: Sample 0x8000 gives coarse 0, fine 1024, and thermometer all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered on `in_data` |
| in_ready | output | 1 | Holding register can take a sample |
| in_data | input | 16 | Two's-complement sample |
| load | input | 1 | Copy the held sample to the outputs on this edge |
| coarse_o | output | 5 | Binary coarse value |
| therm_o | output | 32 | Thermometer controls for the coarse sources |
| fine_o | output | 11 | Binary controls for the fine divider |

## Verification
Suppose the pending flag is wrong. That shows on `in_ready` in the same cycle, because the flag is combined with `load` combinationally. A sample dropped or taken twice shows on the outputs one cycle after the next load. A decode fault shows in the cycle right after the load that carries the affected code, so the bench compares all outputs after every edge. The sequences it drives include the zero crossing, both ends of the range, and a load on the same edge as an accept. In those cases a coarse bit that toggles, or an off-by-one in the offset, shows up as a differing coarse value or thermometer.

// File: rtl/sosd_pkg.sv
package sosd_pkg;
  localparam int SOSD_DATA_W = 16;
  localparam int SOSD_FINE_W = 11;
endpackage

// File: rtl/sosd_in_stage.sv
module sosd_in_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              load_i,
  output logic [DATA_W-1:0] hold_o
);
  logic              pend_q;
  logic [DATA_W-1:0] hold_q;
  logic              take;

  assign in_ready = !pend_q || load_i;
  assign take     = in_valid && in_ready;
  assign hold_o   = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (take) begin
        hold_q <= in_data;
        pend_q <= 1'b1;
      end else if (load_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load_i) |=> !in_ready || load_i); // R2
endmodule

// File: rtl/sosd_map.sv
module sosd_map #(
  parameter int DATA_W   = 16,
  parameter int FINE_W   = 11,
  localparam int COARSE_W = DATA_W - FINE_W
) (
  input  logic [DATA_W-1:0]   sample_i,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_o
);
  localparam logic [DATA_W-1:0] SIGN_FLIP = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W:0]   HALF_SEG  = (DATA_W + 1)'(1) << (FINE_W - 1);

  logic [DATA_W-1:0] offs;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] lvl;

  always_comb begin
    offs = sample_i ^ SIGN_FLIP;
    sum  = {1'b0, offs} + HALF_SEG;
    lvl  = sum[DATA_W] ? '1 : sum[DATA_W-1:0];
  end

  assign coarse_o = lvl[DATA_W-1:FINE_W];
  assign fine_o   = lvl[FINE_W-1:0];
endmodule

// File: rtl/sosd_therm.sv
module sosd_therm #(
  parameter int COARSE_W = 5,
  localparam int SRC_N   = 1 << COARSE_W
) (
  input  logic [COARSE_W-1:0] coarse_i,
  output logic [SRC_N-1:0]    therm_o
);
  for (genvar k = 0; k < SRC_N; k++) begin : g_src
    assign therm_o[k] = (int'(coarse_i) > k);
  end
endmodule

// File: rtl/sosd_out_reg.sv
module sosd_out_reg #(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 11,
  localparam int SRC_N   = 1 << COARSE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [COARSE_W-1:0] coarse_d,
  input  logic [SRC_N-1:0]    therm_d,
  input  logic [FINE_W-1:0]   fine_d,
  input  logic [COARSE_W-1:0] coarse_rst,
  input  logic [SRC_N-1:0]    therm_rst,
  input  logic [FINE_W-1:0]   fine_rst,
  output logic [COARSE_W-1:0] coarse_q,
  output logic [SRC_N-1:0]    therm_q,
  output logic [FINE_W-1:0]   fine_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= coarse_rst;
      therm_q  <= therm_rst;
      fine_q   <= fine_rst;
    end else if (load_i) begin
      coarse_q <= coarse_d;
      therm_q  <= therm_d;
      fine_q   <= fine_d;
    end
  end

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(coarse_q) && $stable(therm_q) && $stable(fine_q)); // R3
  AST_THERM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(therm_q) == int'(coarse_q)); // R6
  AST_THERM_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    ((therm_q + SRC_N'(1)) & therm_q) == '0); // R6
endmodule

// File: rtl/sosd_decoder.sv
module sosd_decoder
  import sosd_pkg::*;
#(
  parameter int DATA_W   = SOSD_DATA_W,
  parameter int FINE_W   = SOSD_FINE_W,
  localparam int COARSE_W = DATA_W - FINE_W,
  localparam int SRC_N    = 1 << COARSE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                load,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [SRC_N-1:0]    therm_o,
  output logic [FINE_W-1:0]   fine_o
);
  logic [DATA_W-1:0]   held;
  logic [COARSE_W-1:0] coarse_d, coarse_z;
  logic [FINE_W-1:0]   fine_d, fine_z;
  logic [SRC_N-1:0]    therm_d, therm_z;

  sosd_in_stage #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .load_i(load), .hold_o(held)
  );

  sosd_map #(.DATA_W(DATA_W), .FINE_W(FINE_W)) u_map (
    .sample_i(held), .coarse_o(coarse_d), .fine_o(fine_d)
  );

  sosd_therm #(.COARSE_W(COARSE_W)) u_therm (
    .coarse_i(coarse_d), .therm_o(therm_d)
  );

  sosd_map #(.DATA_W(DATA_W), .FINE_W(FINE_W)) u_map_zero (
    .sample_i('0), .coarse_o(coarse_z), .fine_o(fine_z)
  );

  sosd_therm #(.COARSE_W(COARSE_W)) u_therm_zero (
    .coarse_i(coarse_z), .therm_o(therm_z)
  );

  sosd_out_reg #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .coarse_d(coarse_d), .therm_d(therm_d), .fine_d(fine_d),
    .coarse_rst(coarse_z), .therm_rst(therm_z), .fine_rst(fine_z),
    .coarse_q(coarse_o), .therm_q(therm_o), .fine_q(fine_o)
  );

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !held[DATA_W-1] && (&held[DATA_W-2:FINE_W-1]))
      |=> (&coarse_o) && (&fine_o)); // R8
  AST_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (load && held == (DATA_W'(1) << (DATA_W - 1)))
      |=> coarse_o == '0 && therm_o == '0); // R9
endmodule

// File: tb/sim_sosd_decoder.sv
module sim_sosd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        load = 1'b0;
  logic [4:0]  coarse_o;
  logic [31:0] therm_o;
  logic [10:0] fine_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  int          m_hold = 0;
  bit          m_pend = 0;
  int          m_out  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sosd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .load(load), .coarse_o(coarse_o),
    .therm_o(therm_o), .fine_o(fine_o)
  );

  function automatic int lvl_of(input int x);
    int u = (x & 16'hFFFF) ^ 32'h8000;
    int l = u + 1024;
    if (l > 65535) l = 65535;
    return l;
  endfunction

  function automatic logic [31:0] therm_of(input int c);
    logic [31:0] t = '0;
    for (int k = 0; k < 32; k++) if (k < c) t[k] = 1'b1;
    return t;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_out(input string tag);
    int l = lvl_of(m_out);
    chk(tag, "coarse", 32'(coarse_o), 32'(l / 2048));
    chk(tag, "fine",   32'(fine_o),   32'(l % 2048));
    chk({tag, "/R6"}, "therm", therm_o, therm_of(l / 2048));
  endtask

  task automatic step(input bit v, input int d, input bit ld, input string tag);
    bit rdy;
    @(negedge clk);
    in_valid = v; in_data = 16'(d); load = ld;
    #1;
    rdy = !m_pend || ld;
    chk({tag, "/R2"}, "in_ready", 32'(in_ready), 32'(rdy));
    @(posedge clk);
    if (ld) m_out = m_hold;
    if (v && rdy) begin m_hold = d & 16'hFFFF; m_pend = 1; end
    else if (ld) m_pend = 0;
    #2;
    chk_out(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0]  c_prev;
    logic [31:0] t_prev;
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "in_ready", 32'(in_ready), 32'd1);
    chk("R1", "coarse", 32'(coarse_o), 32'd16);
    chk("R1", "fine", 32'(fine_o), 32'd1024);
    chk("R1", "therm", therm_o, 32'h0000FFFF);
    @(negedge clk); rst_n = 1'b1;

    // R2: accept, then blocked while pending; R3: outputs hold
    step(1, 16'hFFFF, 0, "R2");
    step(1, 16'h1234, 0, "R3");
    step(0, 0, 0, "R3");
    // R4: load shows 0xFFFF, accept 0x0000 on same edge
    step(0, 0, 1, "R4");
    c_prev = coarse_o; t_prev = therm_o;
    chk("R7", "fine before", 32'(fine_o), 32'd1023);
    step(1, 16'h0000, 1, "R4");
    chk("R4", "still FFFF", 32'(fine_o), 32'd1023);
    step(0, 0, 1, "R7");
    chk("R7", "coarse same", 32'(coarse_o), 32'(c_prev));
    chk("R7", "therm same", therm_o, t_prev);
    chk("R7", "fine after", 32'(fine_o), 32'd1024);
    // R4: load with nothing pending
    step(0, 0, 1, "R4");
    // R9 bottom
    step(1, 16'h8000, 0, "R9");
    step(0, 0, 1, "R9");
    chk("R9", "coarse", 32'(coarse_o), 0);
    chk("R9", "therm", therm_o, 0);
    // R8 top saturation and edge
    step(1, 16'h7C00, 1, "R8");
    step(1, 16'h7FFF, 1, "R8");
    chk("R8", "coarse 7C00", 32'(coarse_o), 31);
    step(1, 16'h7BFF, 1, "R8");
    chk("R8", "fine 7FFF", 32'(fine_o), 2047);
    step(1, 16'h7BFE, 1, "R8");
    chk("R8", "fine 7BFF", 32'(fine_o), 2047);
    step(0, 0, 1, "R5");
    chk("R5", "fine 7BFE", 32'(fine_o), 2046);
    // R5 mixed stream
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[5], {lf[7:0], lf[15:8]}, lf[3] & ~lf[9], "R5");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule